// File: doc/BRIEF.md
# Diagnostic Serial Readback Unit

This unit owns the serial data output of a sixteen-channel LED driver that sits in a daisy chain. Its default job is to pass the chain along. The output carries the top bit of a 16-bit input shift register, which advances on every rising edge of the serial clock. A command is a count of serial clock rising edges taken while the latch line is high, and it is decoded when the latch line falls. When that command asks for status, the unit swaps in a 16-bit word and shifts it out, most significant bit first, over the rising edges that follow. Three words can be sent this way: the configuration word, the per-channel LED fault result, and the thermal flag.

The unit also runs the LED fault test. A start command selects which comparators the analog side must arm: the open check (current), the short check (voltage), or both. Only channels that are switched on and have a nonzero brightness take part in the test. The end command captures the comparator outputs into the result word. One configuration bit moves output updates from the rising to the falling serial clock edge, which gives the next device in the chain more hold margin. A two-bit configuration field selects the short-detect threshold code that goes to the comparators.

The serial clock and latch lines are treated as slow, synchronous inputs. They are sampled by the system clock, and their edges are found from one stored copy of each.

Top module: `diag_readback`

## Requirements
- R1: After reset the configuration word, the switch mask and the brightness flags are all zero. Also after reset, `sdo`, `shortThresh`, `detOpenEn` and `detShortEn` are 0.
- R2: The unit counts the serial clock rising edges seen while `le` is high, and acts on that count when `le` falls. The count is 1 or 2 for a switch write, 3 or 4 for a brightness data latch, 5 or 6 for a brightness commit, 7 for a configuration write and 8 for a configuration read. It is 9 for an open test start, 10 for a short test start, 11 for a combined test start, 12 for a test end and 13 for a thermal read. Each write stores the 16 bits most recently shifted in.
- R3: With no readback in progress and configuration bit 13 clear, `sdo` shows the bit that was shifted in 16 rising edges earlier. It updates in the rising edge that shifts.
- R4: After a read or test-end command, rising edge k (k = 1..16) puts bit 16-k of the status word on `sdo`. Bit 0 therefore stays on `sdo` until the 17th rising edge.
- R5: At the 17th rising edge after a read or test-end command, `sdo` goes back to the shift register's top bit.
- R6: A configuration read (count 8) shifts out the current configuration word.
- R7: A thermal read (count 13) shifts out sixteen copies of `overTemp` as sampled when the command is decoded.
- R8: A start command sets `detOpenEn` (open check), `detShortEn` (short check) or both (combined). It does so only when configuration bit 7 is 0, and a start with bit 7 set leaves both enables low. The test-end command clears both enables.
- R9: A channel is under test when its switch bit is 1 and its brightness flag is 1. At test end, each channel's result bit is 1 if the channel is not under test. Otherwise it is the AND of the `openOk` bit and the `shortOk` bit for the enabled checks, where 1 means the LED is good. Channel 15 is the first bit out.
- R10: A test end with no test running shifts out sixteen 1s.
- R11: A brightness data latch shifts the flag "word is nonzero" into a staging vector. A commit loads the staging vector plus the flag of its own word into the per-channel brightness flags. The first of the 16 words lands on channel 15, and the word of the commit lands on channel 0.
- R12: With configuration bit 13 set, `sdo` changes only in the cycle after a falling serial clock edge. It then shows what rising-edge mode would show at that point.
- R13: `shortThresh` equals configuration bits 9:8 (00, 01, 10 and 11 select the four rising threshold levels). It changes only after a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock level, sampled by clk |
| sdi | input | 1 | Serial data input |
| le | input | 1 | Latch / command line |
| openOk | input | 16 | Open-check comparator result per channel, 1 = good |
| shortOk | input | 16 | Short-check comparator result per channel, 1 = good |
| overTemp | input | 1 | Thermal flag from the sensor |
| sdo | output | 1 | Serial data output to the next device |
| shortThresh | output | 2 | Short-detect threshold code for the comparators |
| detOpenEn | output | 1 | Arms the open (current) check |
| detShortEn | output | 1 | Arms the short (voltage) check |

## Verification
The two functions that can meet in one serial clock edge are the readback shifter and the normal shift path. During a readback every rising edge still shifts `sdi` into the main register. On the 17th edge the output must hand over from readback bit 0 to the shift register's top bit. That top bit was changed by the same edge. The bench drives random data on `sdi` throughout each readback and follows the main register in its own model. It then checks the 17th-edge value against that model, in both edge modes. In falling-edge mode it also checks that the rising half of each pulse still shows the previous bit.

// File: rtl/diag_rb_pkg.sv
package diag_rb_pkg;
  localparam int CH = 16;
  localparam int KEYW = 5;

  // command keys: rising serial edges counted while the latch line is high
  localparam int KEY_SW_A  = 1;
  localparam int KEY_SW_B  = 2;
  localparam int KEY_BD_A  = 3;
  localparam int KEY_BD_B  = 4;
  localparam int KEY_BG_A  = 5;
  localparam int KEY_BG_B  = 6;
  localparam int KEY_WCFG  = 7;
  localparam int KEY_RCFG  = 8;
  localparam int KEY_OPEN  = 9;
  localparam int KEY_SHORT = 10;
  localparam int KEY_BOTH  = 11;
  localparam int KEY_END   = 12;
  localparam int KEY_THERM = 13;

  // configuration bit positions that the logic decodes
  localparam int CFG_NODET   = 7;
  localparam int CFG_THR_LO  = 8;
  localparam int CFG_SDOFALL = 13;

  typedef struct packed {
    logic sRise;
    logic sFall;
    logic wrSwitch;
    logic wrBrtData;
    logic wrBrtGlobal;
    logic wrCfg;
    logic rdCfg;
    logic detOpen;
    logic detShort;
    logic detEnd;
    logic rdTherm;
  } strobe_t;
endpackage

// File: rtl/diag_rb_ctrl.sv
module diag_rb_ctrl
  import diag_rb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    le,
  output strobe_t strb
);
  localparam logic [KEYW-1:0] CNT_MAX = '1;

  logic sclkQ, leQ;
  logic [KEYW-1:0] leCnt;
  logic rise, fall, leFall;

  assign rise   = sclk & ~sclkQ;
  assign fall   = ~sclk & sclkQ;
  assign leFall = leQ & ~le;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      leQ   <= 1'b0;
      leCnt <= '0;
    end else begin
      sclkQ <= sclk;
      leQ   <= le;
      if (leFall)
        leCnt <= '0;
      else if (rise && le && leCnt != CNT_MAX)
        leCnt <= leCnt + 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    strb.sRise = rise;
    strb.sFall = fall;
    if (leFall) begin
      case (int'(leCnt))
        KEY_SW_A, KEY_SW_B: strb.wrSwitch    = 1'b1;
        KEY_BD_A, KEY_BD_B: strb.wrBrtData   = 1'b1;
        KEY_BG_A, KEY_BG_B: strb.wrBrtGlobal = 1'b1;
        KEY_WCFG:           strb.wrCfg       = 1'b1;
        KEY_RCFG:           strb.rdCfg       = 1'b1;
        KEY_OPEN:           strb.detOpen     = 1'b1;
        KEY_SHORT:          strb.detShort    = 1'b1;
        KEY_BOTH: begin
          strb.detOpen  = 1'b1;
          strb.detShort = 1'b1;
        end
        KEY_END:            strb.detEnd      = 1'b1;
        KEY_THERM:          strb.rdTherm     = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/diag_rb_dp.sv
module diag_rb_dp
  import diag_rb_pkg::*;
#(
  parameter int CHN = CH
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic                         sdi,
  input  logic [CHN-1:0]               openOk,
  input  logic [CHN-1:0]               shortOk,
  input  logic                         overTemp,
  output logic                         sdo,
  output logic [1:0]                   shortThresh,
  output logic                         detOpenEn,
  output logic                         detShortEn,
  output logic [CHN-1:0]               cfgWord,
  output logic [$clog2(CHN+1)-1:0]     rbCnt,
  output logic                         rbShow
);
  localparam int CNTW = $clog2(CHN + 1);
  localparam logic [CNTW-1:0] RB_LEN = CNTW'(CHN);

  logic [CHN-1:0] shReg, swOn, brtStage, brtNz, rbWord, detResult, statusWord;
  logic rbBit, fallView, riseView, wordNz, loadRb;

  assign wordNz = |shReg;
  assign loadRb = strb.rdCfg | strb.detEnd | strb.rdTherm;

  // per-channel test outcome
  for (genvar c = 0; c < CHN; c++) begin : g_chan
    logic underTest, okBit;
    assign underTest = swOn[c] & brtNz[c];
    assign okBit     = (~detOpenEn | openOk[c]) & (~detShortEn | shortOk[c]);
    assign detResult[c] = ~underTest | okBit;
  end

  always_comb begin
    if (strb.rdCfg)        statusWord = cfgWord;
    else if (strb.rdTherm) statusWord = {CHN{overTemp}};
    else                   statusWord = detResult;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg      <= '0;
      cfgWord    <= '0;
      swOn       <= '0;
      brtStage   <= '0;
      brtNz      <= '0;
      detOpenEn  <= 1'b0;
      detShortEn <= 1'b0;
    end else begin
      if (strb.sRise)       shReg    <= {shReg[CHN-2:0], sdi};
      if (strb.wrCfg)       cfgWord  <= shReg;
      if (strb.wrSwitch)    swOn     <= shReg;
      if (strb.wrBrtData)   brtStage <= {brtStage[CHN-2:0], wordNz};
      if (strb.wrBrtGlobal) brtNz    <= {brtStage[CHN-2:0], wordNz};
      if (strb.detEnd) begin
        detOpenEn  <= 1'b0;
        detShortEn <= 1'b0;
      end else if ((strb.detOpen | strb.detShort) && !cfgWord[CFG_NODET]) begin
        detOpenEn  <= strb.detOpen;
        detShortEn <= strb.detShort;
      end
    end
  end

  // readback shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbWord <= '0;
      rbCnt  <= '0;
      rbBit  <= 1'b0;
      rbShow <= 1'b0;
    end else if (loadRb) begin
      rbWord <= statusWord;
      rbCnt  <= RB_LEN;
      rbShow <= 1'b0;
    end else if (strb.sRise) begin
      if (rbCnt != '0) begin
        rbBit  <= rbWord[CHN-1];
        rbWord <= {rbWord[CHN-2:0], 1'b0};
        rbCnt  <= rbCnt - 1'b1;
        rbShow <= 1'b1;
      end else begin
        rbShow <= 1'b0;
      end
    end
  end

  assign riseView = rbShow ? rbBit : shReg[CHN-1];

  always_ff @(posedge clk) begin
    if (!rstN)            fallView <= 1'b0;
    else if (strb.sFall)  fallView <= riseView;
  end

  assign sdo         = cfgWord[CFG_SDOFALL] ? fallView : riseView;
  assign shortThresh = cfgWord[CFG_THR_LO+1:CFG_THR_LO];
endmodule

// File: rtl/diag_readback.sv
module diag_readback
  import diag_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          le,
  input  logic [CH-1:0] openOk,
  input  logic [CH-1:0] shortOk,
  input  logic          overTemp,
  output logic          sdo,
  output logic [1:0]    shortThresh,
  output logic          detOpenEn,
  output logic          detShortEn
);
  strobe_t strb;
  logic [CH-1:0] cfgWord;
  logic [$clog2(CH+1)-1:0] rbCnt;
  logic rbShow;

  diag_rb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .le(le), .strb(strb)
  );

  diag_rb_dp #(.CHN(CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdi(sdi),
    .openOk(openOk), .shortOk(shortOk), .overTemp(overTemp),
    .sdo(sdo), .shortThresh(shortThresh),
    .detOpenEn(detOpenEn), .detShortEn(detShortEn),
    .cfgWord(cfgWord), .rbCnt(rbCnt), .rbShow(rbShow)
  );
endmodule

// File: rtl/diag_rb_chk.sv
module diag_rb_chk
  import diag_rb_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input strobe_t                  strb,
  input logic [CH-1:0]            cfgWord,
  input logic [$clog2(CH+1)-1:0]  rbCnt,
  input logic                     rbShow,
  input logic                     sdo,
  input logic [1:0]               shortThresh,
  input logic                     detOpenEn,
  input logic                     detShortEn
);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    rbCnt <= CH);

  a_r5_return_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rbShow) |-> ($past(strb.sRise) || $past(strb.rdCfg | strb.detEnd | strb.rdTherm)));

  a_r12_fall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[CFG_SDOFALL] && $past(cfgWord[CFG_SDOFALL]) && !$past(strb.sFall)) |-> $stable(sdo));

  a_r13_thresh_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shortThresh) |-> $past(strb.wrCfg));

  a_r8_start_gate: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(detOpenEn) || $rose(detShortEn)) |->
      ($past(strb.detOpen | strb.detShort) && !$past(cfgWord[CFG_NODET])));

  a_r8_end_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.detEnd |=> (!detOpenEn && !detShortEn));
endmodule

bind diag_readback diag_rb_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .cfgWord(cfgWord),
  .rbCnt(rbCnt), .rbShow(rbShow), .sdo(sdo), .shortThresh(shortThresh),
  .detOpenEn(detOpenEn), .detShortEn(detShortEn)
);

// File: tb/tb_diag_readback.sv
module tb_diag_readback;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, le = 1'b0, overTemp = 1'b0;
  logic [15:0] openOk = '1, shortOk = '1;
  logic sdo, detOpenEn, detShortEn;
  logic [1:0] shortThresh;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] mSh = '0, mCfg = '0, mSw = '0, mBrt = '0;
  logic sampR, sampF;

  always #5 clk = ~clk;

  diag_readback dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .le(le),
    .openOk(openOk), .shortOk(shortOk), .overTemp(overTemp),
    .sdo(sdo), .shortThresh(shortThresh),
    .detOpenEn(detOpenEn), .detShortEn(detShortEn)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic d, logic l);
    @(negedge clk);
    sdi = d; le = l; sclk = 1'b1;
    repeat (2) @(negedge clk);
    sampR = sdo;
    mSh = {mSh[14:0], d};
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    sampF = sdo;
  endtask

  task automatic sendCmd(logic [15:0] w, int n);
    for (int i = 15; i >= 0; i--) pulse(w[i], i < n);
    @(negedge clk);
    le = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // expected status readback; falling selects configuration bit 13 behaviour
  task automatic readCheck(logic [15:0] exp, string req, bit falling);
    for (int k = 1; k <= 16; k++) begin
      pulse(1'($urandom), 1'b0);
      if (!falling) check({req, " R4 bit"}, sampR, exp[16-k]);
      else begin
        check({req, " R12 after fall"}, sampF, exp[16-k]);
        if (k > 1) check("R12 rise holds", sampR, exp[17-k]);
      end
    end
    pulse(1'($urandom), 1'b0);
    if (!falling) check("R5 return", sampR, mSh[15]);
    else begin
      check("R12 bit0 held", sampR, exp[0]);
      check("R5 return fall", sampF, mSh[15]);
    end
  endtask

  function automatic logic [15:0] detExp(bit o, bit s);
    logic [15:0] ok = (o ? openOk : 16'hFFFF) & (s ? shortOk : 16'hFFFF);
    return ~(mSw & mBrt) | ok;
  endfunction

  task automatic writeCfg(logic [15:0] c);
    sendCmd(c, 7);
    mCfg = c;
    check("R13 thresh", shortThresh, c[9:8]);
  endtask

  task automatic loadChannels();
    logic [15:0] w;
    w = 16'($urandom);
    sendCmd(w, (w[0] ? 1 : 2));
    mSw = w;
    for (int k = 0; k < 16; k++) begin
      w = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom);
      sendCmd(w, (k == 15) ? (5 + (k & 1)) : (3 + (k & 1)));
      mBrt[15-k] = (w != 0);
    end
  endtask

  task automatic runDet(int key, bit o, bit s);
    logic [15:0] e;
    sendCmd(16'($urandom), key);
    check("R8 open enable", detOpenEn, o);
    check("R8 short enable", detShortEn, s);
    openOk = 16'($urandom);
    shortOk = 16'($urandom);
    e = detExp(o, s);
    sendCmd(16'($urandom), 12);
    check("R8 end clears", {detOpenEn, detShortEn}, 2'b00);
    readCheck(e, "R9 result", 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 sdo", sdo, 0);
    check("R1 thresh", shortThresh, 0);
    check("R1 enables", {detOpenEn, detShortEn}, 0);

    // R3: plain shift path
    for (int i = 0; i < 40; i++) begin
      pulse(1'($urandom), 1'b0);
      check("R3 shift", sampR, mSh[15]);
    end

    // R2 / R13 / R6: write then read configuration
    writeCfg(16'($urandom) & ~16'h2080);
    sendCmd(16'($urandom), 8);
    readCheck(mCfg, "R6 cfg", 1'b0);
    writeCfg(16'h0300);
    sendCmd(16'($urandom), 8);
    readCheck(16'h0300, "R6 cfg corner", 1'b0);

    // R7: thermal read both ways
    overTemp = 1'b1;
    sendCmd(16'($urandom), 13);
    readCheck(16'hFFFF, "R7 therm hot", 1'b0);
    overTemp = 1'b0;
    sendCmd(16'($urandom), 13);
    readCheck(16'h0000, "R7 therm cool", 1'b0);

    // R11 / R9 / R8: fault tests in all three modes
    writeCfg(16'h0100);
    loadChannels();
    runDet(9, 1, 0);
    runDet(10, 0, 1);
    loadChannels();
    runDet(11, 1, 1);

    // R10: end with nothing running
    openOk = '0; shortOk = '0;
    sendCmd(16'($urandom), 12);
    readCheck(16'hFFFF, "R10 idle end", 1'b0);

    // R8: start blocked by configuration bit 7
    writeCfg(16'h0080);
    sendCmd(16'($urandom), 11);
    check("R8 blocked", {detOpenEn, detShortEn}, 2'b00);
    sendCmd(16'($urandom), 12);
    readCheck(16'hFFFF, "R10 blocked end", 1'b0);

    // R12: falling-edge output mode
    writeCfg(16'h2000 | (16'($urandom) & 16'h1F7F));
    sendCmd(16'($urandom), 8);
    readCheck(mCfg, "R6 cfg falling", 1'b1);
    for (int i = 0; i < 20; i++) begin
      pulse(1'($urandom), 1'b0);
      check("R12 shift fall", sampF, mSh[15]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule